// File: doc/BRIEF.md
# Data-Strobe Serial Link Encoder and Decoder

This block is a transmitter and receiver pair for a two-wire synchronous serial link. The link needs no separate clock wire. The transmit half takes a parallel word and a one-cycle start request. It then drives two lines. The data line carries the word's bits in turn. The strobe line toggles only in those bit periods where the data line would otherwise stay still. As a result, every bit period shows exactly one edge on exactly one of the two wires.

The receive half watches the two incoming lines through multi-flop synchronizers. It forms the exclusive-OR of the synchronized levels and treats each change of that signal as the arrival of one bit. It shifts the bits in, counts them into words, and presents each complete word together with a one-cycle valid pulse.

Both halves run on one system clock. That clock must be at least four times the bit rate. The transmitter sets its bit period as a whole number of system clocks.

Top module: `ds_link`

## Requirements
- R1: After reset, tx_data_o, tx_strb_o, tx_busy_o and rx_valid_o are all 0. The transmitter's record of the last data bit also starts at 0.
- R2: A word is sent least significant bit first. Bit i appears on tx_data_o from the clock edge that accepts the start request plus i*BIT_DIV cycles, and it is held for BIT_DIV cycles.
- R3: At the start of each bit period, tx_strb_o toggles if and only if the new data bit equals the data level of the previous bit period. For the first word after reset, the previous level is 0.
- R4: At every bit boundary exactly one of tx_data_o and tx_strb_o changes. The two lines never change on the same clock edge.
- R5: A start request with tx_busy_o low is accepted. tx_busy_o is then high for exactly WORD_W*BIT_DIV cycles. Between words, with no request, both lines hold their levels.
- R6: A start request while tx_busy_o is high is ignored. This includes a request in the final cycle of a word. Such a request alters neither the bits sent nor the busy length.
- R7: The receiver treats every change of (synchronized data XOR synchronized strobe) as one bit and takes the bit value from the synchronized data line. After the WORD_W-th bit it shows the word on rx_word_o, least significant bit first, and pulses rx_valid_o high for one cycle.
- R8: Words sent back to back, with the next start accepted one cycle after busy drops, are each decoded exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_start_i | input | 1 | One-cycle request to send tx_word_i |
| tx_word_i | input | WORD_W | Word to send |
| tx_busy_o | output | 1 | High while a word is on the lines |
| tx_data_o | output | 1 | Outgoing data line |
| tx_strb_o | output | 1 | Outgoing strobe line |
| rx_data_i | input | 1 | Incoming data line, asynchronous |
| rx_strb_i | input | 1 | Incoming strobe line, asynchronous |
| rx_word_o | output | WORD_W | Last received word |
| rx_valid_o | output | 1 | One-cycle pulse when rx_word_o is updated |

## Verification
Two events can fall in the same cycle: a fresh start request and the edge that ends the current word and clears busy. The bench raises a request with a different word in the last cycle of every other word. It then checks three things. Busy still falls after exactly WORD_W*BIT_DIV cycles. Neither line moves in the following cycle. The decoder outputs only the original word. All 256 words are looped back from the transmit pins into the receive pins, back to back. The bench compares each bit period's line levels with the encoding rule, which it computes itself from the word and from the line levels it tracks.

// File: rtl/ds_pkg.sv
// Shared helpers for the data-strobe link.
package ds_pkg;
    // Next strobe level: toggle when the new data bit repeats the old one.
    function automatic logic strobe_next(input logic cur_strb,
                                         input logic old_data,
                                         input logic new_data);
        return cur_strb ^ (old_data ~^ new_data);
    endfunction
endpackage

// File: rtl/ds_bit_timer.sv
// Bit-period timer: counts DIV system clocks and flags the last one.
// Assumes DIV >= 2. A clear restarts the period at count zero.
module ds_bit_timer #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int CNT_W = $clog2(DIV);

    logic [CNT_W-1:0] cnt;

    assign tick_o = run_i && !clr_i && (cnt == CNT_W'(DIV - 1));

    // Advance the period counter while running; wrap on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (clr_i || tick_o)  cnt <= '0;
        else if (run_i)            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ds_sync.sv
// Multi-flop synchronizer for one asynchronous line. Assumes STAGES >= 2.
// It resets to 0, which matches the idle level of the link.
module ds_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/ds_encoder.sv
// Transmit half. On an accepted start it sends W bits, LSB first, for DIV
// clocks each. The data line carries each bit. The strobe line toggles
// when a bit repeats the previous one. The previous bit is the current
// data level, which resets to 0. Requests while busy are dropped.
module ds_encoder #(
    parameter int W   = 8,
    parameter int DIV = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] word_i,
    output logic         data_o,
    output logic         strb_o,
    output logic         busy_o
);
    import ds_pkg::*;

    localparam int IDX_W = $clog2(W);

    logic             accept;
    logic             tick;
    logic             last_bit;
    logic [W-2:0]     pend;
    logic [IDX_W-1:0] idx;

    assign accept   = start_i && !busy_o;
    assign last_bit = (idx == IDX_W'(W - 1));

    ds_bit_timer #(.DIV(DIV)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (accept),
        .run_i  (busy_o),
        .tick_o (tick)
    );

    // Load a word, step one bit per period, and drive both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= 1'b0;
            strb_o <= 1'b0;
            busy_o <= 1'b0;
            pend   <= '0;
            idx    <= '0;
        end else if (accept) begin
            busy_o <= 1'b1;
            data_o <= word_i[0];
            strb_o <= strobe_next(strb_o, data_o, word_i[0]);
            pend   <= word_i[W-1:1];
            idx    <= '0;
        end else if (busy_o && tick) begin
            if (last_bit) begin
                busy_o <= 1'b0;
            end else begin
                data_o <= pend[0];
                strb_o <= strobe_next(strb_o, data_o, pend[0]);
                pend   <= pend >> 1;
                idx    <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ds_decoder.sv
// Receive half. It synchronizes both lines and counts a bit on every change
// of their XOR, taking the bit value from the data line. After W bits it
// updates the word and pulses valid for one cycle. Assumes the bit period
// is at least 4 clocks and that the lines idle low after reset.
module ds_decoder #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         data_i,
    input  logic         strb_i,
    output logic [W-1:0] word_o,
    output logic         valid_o
);
    localparam int IDX_W = $clog2(W);

    logic             s_data;
    logic             s_strb;
    logic             phase;
    logic             phase_q;
    logic             bit_evt;
    logic [W-2:0]     acc;
    logic [IDX_W-1:0] cnt;

    ds_sync #(.STAGES(STAGES)) u_sync_data (
        .clk (clk), .rst_n (rst_n), .d_i (data_i), .q_o (s_data)
    );
    ds_sync #(.STAGES(STAGES)) u_sync_strb (
        .clk (clk), .rst_n (rst_n), .d_i (strb_i), .q_o (s_strb)
    );

    assign phase   = s_data ^ s_strb;
    assign bit_evt = phase ^ phase_q;

    // Remember the recovered clock phase to find its edges.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= phase;
    end

    // Shift bits in on each event and close the word after W bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            cnt     <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (bit_evt) begin
                acc <= {s_data, acc[W-2:1]};
                if (cnt == IDX_W'(W - 1)) begin
                    cnt     <= '0;
                    word_o  <= {s_data, acc};
                    valid_o <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ds_link.sv
// Data-strobe link top: an independent encoder and decoder on one clock.
// The transmit pins and receive pins are separate so they can be looped
// back or joined to a remote peer.
module ds_link #(
    parameter int WORD_W      = 8,
    parameter int BIT_DIV     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_start_i,
    input  logic [WORD_W-1:0] tx_word_i,
    output logic              tx_busy_o,
    output logic              tx_data_o,
    output logic              tx_strb_o,
    input  logic              rx_data_i,
    input  logic              rx_strb_i,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              rx_valid_o
);
    ds_encoder #(.W(WORD_W), .DIV(BIT_DIV)) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tx_start_i),
        .word_i  (tx_word_i),
        .data_o  (tx_data_o),
        .strb_o  (tx_strb_o),
        .busy_o  (tx_busy_o)
    );

    ds_decoder #(.W(WORD_W), .STAGES(SYNC_STAGES)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_i  (rx_data_i),
        .strb_i  (rx_strb_i),
        .word_o  (rx_word_o),
        .valid_o (rx_valid_o)
    );
endmodule

// File: rtl/ds_link_chk.sv
// Protocol checker for ds_link, attached to every instance by bind.
module ds_link_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_start_i,
    input logic tx_busy_o,
    input logic tx_data_o,
    input logic tx_strb_o,
    input logic rx_valid_o
);
    // R4: the two lines never move on the same edge.
    p_one_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(tx_data_o) || $stable(tx_strb_o));

    // R3: a strobe edge only marks a repeated data level.
    p_strobe_rule_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_strb_o) |-> (tx_data_o == $past(tx_data_o)));

    // R5: an accepted request raises busy on the next edge.
    p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start_i && !tx_busy_o) |=> tx_busy_o);

    // R5: idle with no request keeps both lines still.
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy_o && !tx_start_i) |=> ($stable(tx_data_o) && $stable(tx_strb_o)));

    // R7: valid lasts a single cycle.
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);
endmodule

bind ds_link ds_link_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_start_i (tx_start_i),
    .tx_busy_o  (tx_busy_o),
    .tx_data_o  (tx_data_o),
    .tx_strb_o  (tx_strb_o),
    .rx_valid_o (rx_valid_o)
);

// File: tb/ds_link_tb.sv
module ds_link_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 8;
    localparam int DIV = 4;
    localparam int WATCHDOG = 60000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] word = '0;
    logic         busy, tdat, tstr, valid;
    logic [W-1:0] rword;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    int           rx_count = 0;
    logic [W-1:0] rx_last = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ds_link #(.WORD_W(W), .BIT_DIV(DIV), .SYNC_STAGES(2)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_start_i (start),
        .tx_word_i  (word),
        .tx_busy_o  (busy),
        .tx_data_o  (tdat),
        .tx_strb_o  (tstr),
        .rx_data_i  (tdat),
        .rx_strb_i  (tstr),
        .rx_word_o  (rword),
        .rx_valid_o (valid)
    );

    // Receive monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && valid) begin
            rx_count <= rx_count + 1;
            rx_last  <= rword;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    logic exp_d = 1'b0;
    logic exp_s = 1'b0;

    // Send one word, checking every bit period. If inject is set, extra
    // requests arrive mid-word and in the final cycle of the word.
    task automatic send_word(input logic [W-1:0] w, input bit inject);
        int rx_before;
        rx_before = rx_count;
        start = 1'b1;
        word  = w;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < W; i++) begin
            logic nb, want_s, prev_d, prev_s;
            nb     = w[i];
            prev_d = exp_d;
            prev_s = exp_s;
            want_s = exp_s ^ (nb == exp_d);
            exp_d  = nb;
            exp_s  = want_s;
            check(tdat == nb, "R2 data bit", int'(tdat), int'(nb));
            check(tstr == want_s, "R3 strobe", int'(tstr), int'(want_s));
            check(((tdat != prev_d) ^ (tstr != prev_s)) == 1'b1, "R4 one line",
                  int'({tdat, tstr}), int'({nb, want_s}));
            check(busy == 1'b1, "R5 busy high", int'(busy), 1);
            if (i == W - 1) begin
                repeat (DIV - 1) @(negedge clk);
                if (inject) begin
                    start = 1'b1;
                    word  = ~w;
                end
                @(negedge clk);
                start = 1'b0;
            end else begin
                if (inject && i == 3) begin
                    start = 1'b1;
                    word  = ~w;
                end
                @(negedge clk);
                start = 1'b0;
                repeat (DIV - 1) @(negedge clk);
            end
        end
        check(busy == 1'b0, "R5 busy length", int'(busy), 0);
        check(tdat == exp_d && tstr == exp_s, "R6 lines hold after late request",
              int'({tdat, tstr}), int'({exp_d, exp_s}));
        check(rx_count == rx_before + 1, "R8 one word decoded", rx_count, rx_before + 1);
        check(rx_last == w, "R7 decoded word", int'(rx_last), int'(w));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(tdat == 1'b0 && tstr == 1'b0, "R1 lines low", int'({tdat, tstr}), 0);
        check(busy == 1'b0, "R1 busy low", int'(busy), 0);
        check(valid == 1'b0, "R1 valid low", int'(valid), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(tdat == 1'b0 && tstr == 1'b0, "R5 idle lines", int'({tdat, tstr}), 0);
        check(rx_count == 0, "R7 no spurious word", rx_count, 0);
        for (int v = 0; v < (1 << W); v++) begin
            send_word(W'(v), v[0]);
        end
        repeat (8) @(negedge clk);
        check(rx_count == (1 << W), "R8 total words", rx_count, 1 << W);
        finish_run();
    end
endmodule